// File: doc/BRIEF.md
# Oscillator Enable and Clock Boundary-Scan Segment

This block is a slice of a boundary-scan data register that covers the clock-source pins of a device. Five sources take part: an external clock input, a crystal or ceramic-resonator oscillator, an external RC network, a low-frequency crystal and a timer oscillator. Each source contributes two cells to the serial chain. The first is an update-capable cell on the oscillator enable. Under EXTEST it can replace the enable coming from the digital logic. Sleep logic could otherwise switch an oscillator off and remove its pins from the test path. The second is an observe-only cell on the oscillator clock output. It samples the line through a synchronizer and never alters the path to system logic. The internal RC source has no external pins and is not in the chain.

The segment runs on the test clock. Capture, shift and update come in as synchronous strobes from the test controller. When a source is switched off, its observe cell reads a fixed idle level in place of the line. That level is 1 for the external RC source and 0 for all the others. A flag goes high after an EXTEST update that leaves more than one main-clock enable set. The timer oscillator does not count as a main clock.

Top module: `osc_bscan_seg`

## Requirements
- R1: With `extest` low, `osc_en_o` equals `sys_en_i` bit for bit. In every mode, `clk_line_o` equals `clk_line_i`.
- R2: On a cycle with `dr_capture` high, each enable cell loads its `sys_en_i` bit. Each observe cell loads the clock-line level, provided that level has been steady for at least three cycles.
- R3: The chain is ten cells long and fixed in order: source 0 enable, source 0 clock, source 1 enable, and so on up to source 4 clock. The source numbering is 0 external clock, 1 crystal/resonator, 2 external RC, 3 low-frequency crystal, 4 timer oscillator. Each `dr_shift` cycle moves the chain one place toward `scan_out`, and `scan_out` shows the source 4 clock cell.
- R4: With `extest` high, `osc_en_o` shows the update latches. Each latch takes the value of its enable cell on a `dr_update` cycle.
- R5: Shifting and capturing leave the update latches, and so `osc_en_o` under EXTEST, unchanged until the next `dr_update`.
- R6: When a source's driven enable (`osc_en_o` bit) is 0, its observe cell captures the idle level: 1 for source 2 and 0 for every other source.
- R7: After a `dr_update` with `extest` high, `multi_main_err` is 1 if more than one of sources 0 to 3 has its latch set, and 0 otherwise. Source 4 is ignored. The flag changes on no other cycle.
- R8: While `rst_n` is low, every chain cell, latch and the error flag clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low reset |
| dr_capture | input | 1 | Capture strobe for the data register |
| dr_shift | input | 1 | Shift strobe for the data register |
| dr_update | input | 1 | Update strobe for the data register |
| extest | input | 1 | EXTEST instruction active |
| scan_in | input | 1 | Serial data from the previous segment |
| scan_out | output | 1 | Serial data to the next segment |
| sys_en_i | input | 5 | Oscillator enables from the digital logic |
| osc_en_o | output | 5 | Enables driven to the oscillators |
| clk_line_i | input | 5 | Clock outputs from the oscillators |
| clk_line_o | output | 5 | Clock lines passed on to system logic |
| multi_main_err | output | 1 | More than one main clock enabled by EXTEST |

## Verification
The bench captures with sources switched off and the clock lines held at both levels. A design that gated with the wrong idle polarity would report the RC source as 0, or a stopped crystal as 1. Other tests load enable patterns and shift new data without an update. These catch outputs that follow the shift stage directly, and a chain order in which enable and clock bits are swapped. The error flag is exercised with two main sources set and then with one main source plus the timer. A flag that counted the timer, or that was computed from the shifting data, would report a contention that does not exist.

// File: rtl/osc_bscan_pkg.sv
package osc_bscan_pkg;

   typedef enum int unsigned {
      SRC_EXT_CLK  = 0,
      SRC_XTAL     = 1,
      SRC_EXT_RC   = 2,
      SRC_LF_XTAL  = 3,
      SRC_TIMER    = 4
   } osc_src_e;

   localparam int unsigned DEF_NUM_SRC = 5;

   function automatic int unsigned count_set(input logic [31:0] v, input int unsigned n);
      int unsigned c;
      c = 0;
      for (int unsigned k = 0; k < n; k++) begin
         if (v[k]) c++;
      end
      return c;
   endfunction

endpackage

// File: rtl/osc_bs_gen_cell.sv
module osc_bs_gen_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic capture,
   input  logic shift,
   input  logic update,
   input  logic mode_test,
   input  logic scan_in,
   input  logic func_i,
   output logic func_o,
   output logic scan_q,
   output logic upd_q
);
   logic stage_q;
   logic latch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= 1'b0;
      end else if (capture) begin
         stage_q <= func_i;
      end else if (shift) begin
         stage_q <= scan_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= 1'b0;
      end else if (update) begin
         latch_q <= stage_q;
      end
   end

   assign func_o = mode_test ? latch_q : func_i;
   assign scan_q = stage_q;
   assign upd_q  = latch_q;
endmodule

// File: rtl/osc_bs_obs_cell.sv
module osc_bs_obs_cell #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic        IDLE_LVL    = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic capture,
   input  logic shift,
   input  logic scan_in,
   input  logic src_on,
   input  logic pin_i,
   output logic pin_o,
   output logic scan_q
);
   logic sampled;
   logic stage_q;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign sampled = pin_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sync_q <= '0;
            end else begin
               sync_q[0] <= pin_i;
               for (int unsigned k = 1; k < SYNC_STAGES; k++) begin
                  sync_q[k] <= sync_q[k-1];
               end
            end
         end
         assign sampled = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= 1'b0;
      end else if (capture) begin
         stage_q <= src_on ? sampled : IDLE_LVL;
      end else if (shift) begin
         stage_q <= scan_in;
      end
   end

   assign pin_o  = pin_i;
   assign scan_q = stage_q;
endmodule

// File: rtl/osc_main_guard.sv
module osc_main_guard
   import osc_bscan_pkg::*;
#(
   parameter int unsigned          NUM_SRC   = DEF_NUM_SRC,
   parameter logic [NUM_SRC-1:0]   MAIN_MASK = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               upd_strobe,
   input  logic [NUM_SRC-1:0] next_latch,
   output logic               err_o
);
   logic [31:0] masked;
   logic        over;

   always_comb begin
      masked = '0;
      masked[NUM_SRC-1:0] = next_latch & MAIN_MASK;
      over = count_set(masked, NUM_SRC) > 1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_o <= 1'b0;
      end else if (upd_strobe) begin
         err_o <= over;
      end
   end
endmodule

// File: rtl/osc_bscan_seg.sv
module osc_bscan_seg
   import osc_bscan_pkg::*;
#(
   parameter int unsigned        NUM_SRC     = DEF_NUM_SRC,
   parameter int unsigned        SYNC_STAGES = 2,
   parameter logic [NUM_SRC-1:0] MAIN_MASK   = 5'b01111,
   parameter logic [NUM_SRC-1:0] IDLE_HIGH   = 5'b00100
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dr_capture,
   input  logic               dr_shift,
   input  logic               dr_update,
   input  logic               extest,
   input  logic               scan_in,
   output logic               scan_out,
   input  logic [NUM_SRC-1:0] sys_en_i,
   output logic [NUM_SRC-1:0] osc_en_o,
   input  logic [NUM_SRC-1:0] clk_line_i,
   output logic [NUM_SRC-1:0] clk_line_o,
   output logic               multi_main_err
);
   localparam int unsigned CHAIN_LEN = 2 * NUM_SRC;

   if (NUM_SRC < 1 || NUM_SRC > 32) begin : g_bad_num
      $error("osc_bscan_seg: NUM_SRC out of range");
   end
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("osc_bscan_seg: SYNC_STAGES too deep");
   end

   logic [CHAIN_LEN:0]  chain;
   logic [NUM_SRC-1:0]  en_stage;
   logic [NUM_SRC-1:0]  en_latch;

   assign chain[0] = scan_in;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      osc_bs_gen_cell u_en (
         .clk       (clk),
         .rst_n     (rst_n),
         .capture   (dr_capture),
         .shift     (dr_shift),
         .update    (dr_update),
         .mode_test (extest),
         .scan_in   (chain[2*i]),
         .func_i    (sys_en_i[i]),
         .func_o    (osc_en_o[i]),
         .scan_q    (en_stage[i]),
         .upd_q     (en_latch[i])
      );
      assign chain[2*i+1] = en_stage[i];

      osc_bs_obs_cell #(
         .SYNC_STAGES (SYNC_STAGES),
         .IDLE_LVL    (IDLE_HIGH[i])
      ) u_obs (
         .clk     (clk),
         .rst_n   (rst_n),
         .capture (dr_capture),
         .shift   (dr_shift),
         .scan_in (chain[2*i+1]),
         .src_on  (osc_en_o[i]),
         .pin_i   (clk_line_i[i]),
         .pin_o   (clk_line_o[i]),
         .scan_q  (chain[2*i+2])
      );
   end

   osc_main_guard #(
      .NUM_SRC   (NUM_SRC),
      .MAIN_MASK (MAIN_MASK)
   ) u_guard (
      .clk        (clk),
      .rst_n      (rst_n),
      .upd_strobe (dr_update & extest),
      .next_latch (en_stage),
      .err_o      (multi_main_err)
   );

   assign scan_out = chain[CHAIN_LEN];

   logic unused_latch;
   assign unused_latch = ^en_latch;
endmodule

// File: rtl/osc_bscan_seg_chk.sv
module osc_bscan_seg_chk #(
   parameter int unsigned        NUM_SRC   = 5,
   parameter logic [NUM_SRC-1:0] MAIN_MASK = 5'b01111
) (
   input logic               clk,
   input logic               rst_n,
   input logic               dr_update,
   input logic               extest,
   input logic               scan_out,
   input logic [NUM_SRC-1:0] osc_en_o,
   input logic [NUM_SRC-1:0] clk_line_i,
   input logic [NUM_SRC-1:0] clk_line_o,
   input logic               multi_main_err
);
   p_clk_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      clk_line_o == clk_line_i);

   p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (extest && $past(extest) && !$past(dr_update)) |-> $stable(osc_en_o));

   p_err_only_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(dr_update && extest) |-> $stable(multi_main_err));

   p_err_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(multi_main_err) && extest) |-> ($countones(osc_en_o & MAIN_MASK) > 1));

   p_err_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(multi_main_err) && extest) |-> ($countones(osc_en_o & MAIN_MASK) <= 1));

   p_out_known_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown(scan_out));
endmodule

bind osc_bscan_seg osc_bscan_seg_chk #(
   .NUM_SRC   (NUM_SRC),
   .MAIN_MASK (MAIN_MASK)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .dr_update      (dr_update),
   .extest         (extest),
   .scan_out       (scan_out),
   .osc_en_o       (osc_en_o),
   .clk_line_i     (clk_line_i),
   .clk_line_o     (clk_line_o),
   .multi_main_err (multi_main_err)
);

// File: tb/sim_osc_bscan_seg.sv
module sim_osc_bscan_seg;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dr_capture = 1'b0, dr_shift = 1'b0, dr_update = 1'b0, extest = 1'b0;
   logic       scan_in = 1'b0;
   logic       scan_out;
   logic [4:0] sys_en_i = '0, osc_en_o, clk_line_i = '0, clk_line_o;
   logic       multi_main_err;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   localparam logic [4:0] IDLE = 5'b00100;

   always #5 clk = ~clk;

   osc_bscan_seg u0 (
      .clk(clk), .rst_n(rst_n), .dr_capture(dr_capture), .dr_shift(dr_shift),
      .dr_update(dr_update), .extest(extest), .scan_in(scan_in), .scan_out(scan_out),
      .sys_en_i(sys_en_i), .osc_en_o(osc_en_o), .clk_line_i(clk_line_i),
      .clk_line_o(clk_line_o), .multi_main_err(multi_main_err)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [9:0] chain_img(input logic [4:0] cap_en, input logic [4:0] drv_en,
                                            input logic [4:0] line);
      logic [9:0] v;
      for (int i = 0; i < 5; i++) begin
         v[2*i]   = cap_en[i];
         v[2*i+1] = drv_en[i] ? line[i] : IDLE[i];
      end
      return v;
   endfunction

   function automatic logic [9:0] en_load(input logic [4:0] en);
      logic [9:0] v;
      v = '0;
      for (int i = 0; i < 5; i++) v[2*i] = en[i];
      return v;
   endfunction

   task automatic scan(input logic [9:0] din, output logic [9:0] dout);
      for (int j = 0; j < 10; j++) begin
         @(negedge clk);
         dout[9-j] = scan_out;
         scan_in   = din[9-j];
         dr_shift  = 1'b1;
      end
      @(negedge clk);
      dr_shift = 1'b0;
   endtask

   task automatic capture();
      @(negedge clk);
      dr_capture = 1'b1;
      @(negedge clk);
      dr_capture = 1'b0;
   endtask

   task automatic update();
      @(negedge clk);
      dr_update = 1'b1;
      @(negedge clk);
      dr_update = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      sys_en_i = 5'b10110;
      #1;
      check(scan_out == 1'b0, "R8 scan_out", scan_out, 0);
      check(multi_main_err == 1'b0, "R8 err", multi_main_err, 0);
      check(osc_en_o == 5'b10110, "R1 reset passthrough", osc_en_o, 5'b10110);
   endtask

   task automatic t_functional();
      @(negedge clk);
      extest = 1'b0; sys_en_i = 5'b01001; clk_line_i = 5'b10011;
      #1;
      check(osc_en_o == 5'b01001, "R1 enable passthrough", osc_en_o, 5'b01001);
      check(clk_line_o == 5'b10011, "R1 clock passthrough", clk_line_o, 5'b10011);
   endtask

   task automatic t_capture_run();
      logic [9:0] got, exp;
      @(negedge clk);
      sys_en_i = 5'b11111; clk_line_i = 5'b01010;
      repeat (4) @(negedge clk);
      capture();
      scan('0, got);
      exp = chain_img(5'b11111, 5'b11111, 5'b01010);
      check(got == exp, "R2 R3 capture with all enabled", got, exp);
      sys_en_i = 5'b10101; clk_line_i = 5'b11011;
      repeat (4) @(negedge clk);
      capture();
      scan('0, got);
      exp = chain_img(5'b10101, 5'b10101, 5'b11011);
      check(got == exp, "R3 R6 mixed enables", got, exp);
   endtask

   task automatic t_capture_idle();
      logic [9:0] got, exp;
      @(negedge clk);
      sys_en_i = 5'b00000; clk_line_i = 5'b11111;
      repeat (4) @(negedge clk);
      capture();
      scan('0, got);
      exp = chain_img(5'b00000, 5'b00000, 5'b11111);
      check(got == exp, "R6 idle with lines high", got, exp);
      clk_line_i = 5'b00000;
      repeat (4) @(negedge clk);
      capture();
      scan('0, got);
      exp = chain_img(5'b00000, 5'b00000, 5'b00000);
      check(got == exp, "R6 idle with lines low", got, exp);
   endtask

   task automatic t_extest();
      logic [9:0] got;
      @(negedge clk);
      sys_en_i = 5'b01110; extest = 1'b1;
      #1;
      check(osc_en_o == 5'b00000, "R4 latches after reset", osc_en_o, 0);
      scan(en_load(5'b10001), got);
      #1;
      check(osc_en_o == 5'b00000, "R5 no change before update", osc_en_o, 0);
      update();
      #1;
      check(osc_en_o == 5'b10001, "R4 update drives enables", osc_en_o, 5'b10001);
      check(multi_main_err == 1'b0, "R7 timer not counted", multi_main_err, 0);
      check(clk_line_o == clk_line_i, "R1 clock path in extest", clk_line_o, clk_line_i);
      scan(en_load(5'b00110), got);
      capture();
      #1;
      check(osc_en_o == 5'b10001, "R5 hold across shift and capture", osc_en_o, 5'b10001);
      scan(en_load(5'b00110), got);
      update();
      #1;
      check(osc_en_o == 5'b00110, "R4 second update", osc_en_o, 5'b00110);
      check(multi_main_err == 1'b1, "R7 two main sources", multi_main_err, 1);
      scan(en_load(5'b01000), got);
      #1;
      check(multi_main_err == 1'b1, "R7 flag holds while shifting", multi_main_err, 1);
      update();
      #1;
      check(multi_main_err == 1'b0, "R7 single main source", multi_main_err, 0);
      clk_line_i = 5'b01100;
      repeat (4) @(negedge clk);
      capture();
      scan('0, got);
      check(got == chain_img(5'b01110, 5'b01000, 5'b01100), "R6 gating follows latches",
            got, chain_img(5'b01110, 5'b01000, 5'b01100));
      @(negedge clk);
      extest = 1'b0;
      #1;
      check(osc_en_o == 5'b01110, "R1 back to functional", osc_en_o, 5'b01110);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_functional();
      t_capture_run();
      t_capture_idle();
      t_extest();
      repeat (2) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end
endmodule